// File: doc/BRIEF.md
# Self-Timed Program and Erase Sequencer

This block takes the command bytes of a flash-style memory device once the serial or byte-wide front end has turned them into bytes. It captures a one-byte command code followed by a four-byte address field while chip select is low. Nothing is committed when the last address byte arrives. The command is accepted only when chip select returns high, and only if the whole frame arrived and the code is one the block knows. The block then runs a self-timed operation and holds the ready output low for that operation's fixed duration. The durations for normal program, fast program, single-page erase and eight-page block erase are each set by a parameter in clock cycles.

In the last cycle of the timed window the sequencer sends one strobe to the page array, with the first target page and the page count. A program strobe merges one of two page buffers into a page by bitwise AND. An erase strobe returns every page in the range to all ones. A small parameterised array with two page buffers is part of the block so that the sequencer can be used and tested on its own. It has a buffer load port and a combinational page read port.

Top module: `pes_sequencer`

## Requirements
- R1: After reset, ready is 1, both strobes are 0, and every byte of every page reads 0xFF.
- R2: Code 0x88 programs from buffer 0 and 0x89 from buffer 1 with the normal duration. Code 0x98 programs from buffer 0 and 0x99 from buffer 1 with the fast duration.
- R3: The four address bytes form a 32-bit field, most significant byte first. The page number is field bits 24..11, reduced modulo NUM_PAGES. Field bits 31..25 and 10..0 have no effect.
- R4: While chip select stays low, a complete frame does not start an operation. The operation starts on the clock edge that first sees chip select high, and ready is 0 from the following cycle.
- R5: Ready stays 0 for exactly T_PROG cycles on a normal program, T_FPROG on a fast program, T_PERASE on a page erase and T_BERASE on a block erase.
- R6: A program sets each byte of the page to the old byte AND the buffer byte, so no 0 bit can become 1.
- R7: Code 0x81 sets every byte of the addressed page to 0xFF and leaves all other pages unchanged.
- R8: Code 0x50 erases the eight pages starting at the page number with its low three bits cleared. The low three page bits have no effect.
- R9: A command framed and released while ready is 0 is dropped. It causes no later operation, and the running operation's target does not change.
- R10: If chip select rises before all four address bytes have arrived, no operation starts and ready stays 1.
- R11: A code other than the six above causes no operation.
- R12: Each operation produces exactly one strobe, one cycle long, in its last busy cycle: prog_stb for a program, erase_stb for an erase. During that strobe range_first gives the first page and range_count gives 1 or 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; the rising edge commits a command |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte: command code, then address bytes |
| buf_wr | input | 1 | Write one byte into a page buffer |
| buf_sel | input | 1 | Page buffer selected for the write |
| buf_addr | input | $clog2(PAGE_BYTES) | Byte position within the buffer |
| buf_data | input | 8 | Byte to write |
| rd_page | input | $clog2(NUM_PAGES) | Page to read |
| rd_addr | input | $clog2(PAGE_BYTES) | Byte within the page to read |
| rd_data | output | 8 | Page byte, combinational |
| ready | output | 1 | 1 when idle, 0 during a self-timed operation |
| prog_stb | output | 1 | Program strobe to the array |
| erase_stb | output | 1 | Erase strobe to the array |
| range_first | output | $clog2(NUM_PAGES) | First page of the target range |
| range_count | output | 4 | Number of pages in the target range |

## Verification
The bench builds the block with 32 pages of 8 bytes and durations of 6, 3, 4 and 20 cycles. Every operation kind therefore has its own busy length, and a wrong duration choice shows up as a wrong cycle count. Thirty-two pages make four erase blocks, so an erase that spills over a block edge, or a page number above the array size, lands on pages that are visible through the read port. The 20-cycle block erase is long enough for a second complete frame to be sent and released while the first operation is still busy.

// File: rtl/pes_pkg.sv
package pes_pkg;

    localparam int FRAME_BYTES = 5;
    localparam int BLOCK_PAGES = 8;
    localparam int PAGE_FIELD_W = 14;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_PERASE = 2'd2,
        OP_BERASE = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     fast;
        logic     buf_sel;
    } op_desc_t;

    function automatic op_desc_t decode_op(input logic [7:0] code);
        op_desc_t d;
        d = '{kind: OP_NONE, fast: 1'b0, buf_sel: 1'b0};
        case (code)
            8'h88: d = '{kind: OP_PROG,   fast: 1'b0, buf_sel: 1'b0};
            8'h89: d = '{kind: OP_PROG,   fast: 1'b0, buf_sel: 1'b1};
            8'h98: d = '{kind: OP_PROG,   fast: 1'b1, buf_sel: 1'b0};
            8'h99: d = '{kind: OP_PROG,   fast: 1'b1, buf_sel: 1'b1};
            8'h81: d = '{kind: OP_PERASE, fast: 1'b0, buf_sel: 1'b0};
            8'h50: d = '{kind: OP_BERASE, fast: 1'b0, buf_sel: 1'b0};
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pes_frame_rx.sv
module pes_frame_rx
    import pes_pkg::*;
#(
    parameter int NUM_PAGES = 64,
    localparam int PAGE_AW  = $clog2(NUM_PAGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    output logic               commit,
    output op_desc_t           desc,
    output logic [PAGE_AW-1:0] page
);

    localparam int CNT_W = $clog2(FRAME_BYTES + 1);

    logic                    cs_q;
    logic [CNT_W-1:0]        nbytes;
    op_desc_t                desc_q;
    logic [PAGE_FIELD_W-1:0] pfield;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            nbytes <= '0;
            desc_q <= '{kind: OP_NONE, fast: 1'b0, buf_sel: 1'b0};
            pfield <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                nbytes <= '0;
            end else if (rx_valid && (nbytes < CNT_W'(FRAME_BYTES))) begin
                nbytes <= nbytes + 1'b1;
                case (nbytes)
                    CNT_W'(0): desc_q <= decode_op(rx_byte);
                    CNT_W'(1): pfield[13]   <= rx_byte[0];
                    CNT_W'(2): pfield[12:5] <= rx_byte;
                    CNT_W'(3): pfield[4:0]  <= rx_byte[7:3];
                    default: ;
                endcase
            end
        end
    end

    assign commit = cs_n && !cs_q
                 && (nbytes == CNT_W'(FRAME_BYTES))
                 && (desc_q.kind != OP_NONE);
    assign desc   = desc_q;
    assign page   = PAGE_AW'(pfield % PAGE_FIELD_W'(NUM_PAGES));

endmodule

// File: rtl/pes_op_timer.sv
module pes_op_timer
    import pes_pkg::*;
#(
    parameter int PAGE_AW  = 6,
    parameter int T_PROG   = 2000,
    parameter int T_FPROG  = 800,
    parameter int T_PERASE = 1500,
    parameter int T_BERASE = 4000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  op_desc_t           desc,
    input  logic [PAGE_AW-1:0] page,
    output logic               ready,
    output logic               prog_stb,
    output logic               erase_stb,
    output logic               prog_buf,
    output logic [PAGE_AW-1:0] range_first,
    output logic [3:0]         range_count
);

    localparam int T_MAX_A = (T_PROG > T_FPROG) ? T_PROG : T_FPROG;
    localparam int T_MAX_B = (T_PERASE > T_BERASE) ? T_PERASE : T_BERASE;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam logic [PAGE_AW-1:0] ALIGN_MASK = ~PAGE_AW'(BLOCK_PAGES - 1);

    logic               busy;
    logic [CNT_W-1:0]   remain;
    op_kind_e           kind_q;
    logic               buf_q;
    logic [PAGE_AW-1:0] first_q;
    logic               fire;

    function automatic logic [CNT_W-1:0] op_len(input op_desc_t d);
        case (d.kind)
            OP_PROG:   return d.fast ? CNT_W'(T_FPROG - 1) : CNT_W'(T_PROG - 1);
            OP_PERASE: return CNT_W'(T_PERASE - 1);
            default:   return CNT_W'(T_BERASE - 1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            remain  <= '0;
            kind_q  <= OP_NONE;
            buf_q   <= 1'b0;
            first_q <= '0;
        end else if (!busy) begin
            if (commit) begin
                busy    <= 1'b1;
                remain  <= op_len(desc);
                kind_q  <= desc.kind;
                buf_q   <= desc.buf_sel;
                first_q <= (desc.kind == OP_BERASE) ? (page & ALIGN_MASK) : page;
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    assign fire        = busy && (remain == '0);
    assign ready       = !busy;
    assign prog_stb    = fire && (kind_q == OP_PROG);
    assign erase_stb   = fire && (kind_q != OP_PROG);
    assign prog_buf    = buf_q;
    assign range_first = first_q;
    assign range_count = (kind_q == OP_BERASE) ? 4'(BLOCK_PAGES) : 4'd1;

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(prog_stb && erase_stb));

    // R12
    strobe_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb) |=> ready);

    // R9
    target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !prog_stb && !erase_stb) |=> (!ready && $stable(range_first)));

    // R8
    block_align_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_stb && range_count == 4'(BLOCK_PAGES)) |-> (range_first[2:0] == 3'd0));

endmodule

// File: rtl/pes_page_array.sv
module pes_page_array
    import pes_pkg::*;
#(
    parameter int NUM_PAGES  = 64,
    parameter int PAGE_BYTES = 16,
    localparam int PAGE_AW   = $clog2(NUM_PAGES),
    localparam int BA_W      = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               buf_wr,
    input  logic               buf_sel,
    input  logic [BA_W-1:0]    buf_addr,
    input  logic [7:0]         buf_data,
    input  logic               prog_stb,
    input  logic               erase_stb,
    input  logic               prog_buf,
    input  logic [PAGE_AW-1:0] range_first,
    input  logic [3:0]         range_count,
    input  logic [PAGE_AW-1:0] rd_page,
    input  logic [BA_W-1:0]    rd_addr,
    output logic [7:0]         rd_data
);

    localparam int HW = PAGE_AW + 1;

    logic [7:0]     pbuf [2][PAGE_BYTES];
    logic [7:0]     mem  [NUM_PAGES][PAGE_BYTES];
    logic [HW-1:0]  lo, hi;
    logic [NUM_PAGES-1:0] hit;

    assign lo = {1'b0, range_first};
    assign hi = lo + HW'(range_count);

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_hit
        assign hit[p] = (HW'(p) >= lo) && (HW'(p) < hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 2; s++)
                for (int b = 0; b < PAGE_BYTES; b++)
                    pbuf[s][b] <= 8'h00;
            for (int p = 0; p < NUM_PAGES; p++)
                for (int b = 0; b < PAGE_BYTES; b++)
                    mem[p][b] <= 8'hFF;
        end else begin
            if (buf_wr)
                pbuf[buf_sel][buf_addr] <= buf_data;
            for (int p = 0; p < NUM_PAGES; p++) begin
                for (int b = 0; b < PAGE_BYTES; b++) begin
                    if (erase_stb && hit[p])
                        mem[p][b] <= 8'hFF;
                    else if (prog_stb && hit[p])
                        mem[p][b] <= mem[p][b] & pbuf[prog_buf][b];
                end
            end
        end
    end

    assign rd_data = mem[rd_page][rd_addr];

endmodule

// File: rtl/pes_sequencer.sv
module pes_sequencer
    import pes_pkg::*;
#(
    parameter int NUM_PAGES  = 64,
    parameter int PAGE_BYTES = 16,
    parameter int T_PROG     = 2000,
    parameter int T_FPROG    = 800,
    parameter int T_PERASE   = 1500,
    parameter int T_BERASE   = 4000,
    localparam int PAGE_AW   = $clog2(NUM_PAGES),
    localparam int BA_W      = $clog2(PAGE_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               buf_wr,
    input  logic               buf_sel,
    input  logic [BA_W-1:0]    buf_addr,
    input  logic [7:0]         buf_data,
    input  logic [PAGE_AW-1:0] rd_page,
    input  logic [BA_W-1:0]    rd_addr,
    output logic [7:0]         rd_data,
    output logic               ready,
    output logic               prog_stb,
    output logic               erase_stb,
    output logic [PAGE_AW-1:0] range_first,
    output logic [3:0]         range_count
);

    logic               commit;
    op_desc_t           desc;
    logic [PAGE_AW-1:0] page;
    logic               prog_buf;

    pes_frame_rx #(.NUM_PAGES(NUM_PAGES)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .commit   (commit),
        .desc     (desc),
        .page     (page)
    );

    pes_op_timer #(
        .PAGE_AW  (PAGE_AW),
        .T_PROG   (T_PROG),
        .T_FPROG  (T_FPROG),
        .T_PERASE (T_PERASE),
        .T_BERASE (T_BERASE)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .desc        (desc),
        .page        (page),
        .ready       (ready),
        .prog_stb    (prog_stb),
        .erase_stb   (erase_stb),
        .prog_buf    (prog_buf),
        .range_first (range_first),
        .range_count (range_count)
    );

    pes_page_array #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk         (clk),
        .rst         (rst),
        .buf_wr      (buf_wr),
        .buf_sel     (buf_sel),
        .buf_addr    (buf_addr),
        .buf_data    (buf_data),
        .prog_stb    (prog_stb),
        .erase_stb   (erase_stb),
        .prog_buf    (prog_buf),
        .range_first (range_first),
        .range_count (range_count),
        .rd_page     (rd_page),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    // R4
    start_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(cs_n));

endmodule

// File: tb/tb_pes_sequencer.sv
`timescale 1ns/1ps
module tb_pes_sequencer;

    localparam int NP = 32;
    localparam int PB = 8;
    localparam int TP = 6;
    localparam int TF = 3;
    localparam int TE = 4;
    localparam int TB = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       buf_wr = 1'b0;
    logic       buf_sel = 1'b0;
    logic [2:0] buf_addr = '0;
    logic [7:0] buf_data = '0;
    logic [4:0] rd_page = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ready, prog_stb, erase_stb;
    logic [4:0] range_first;
    logic [3:0] range_count;

    int nchk = 0;
    int nfail = 0;
    int mdl [NP][PB];
    int bufm [2][PB];

    always #2 clk = ~clk;

    pes_sequencer #(
        .NUM_PAGES(NP), .PAGE_BYTES(PB),
        .T_PROG(TP), .T_FPROG(TF), .T_PERASE(TE), .T_BERASE(TB)
    ) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .buf_wr(buf_wr), .buf_sel(buf_sel), .buf_addr(buf_addr), .buf_data(buf_data),
        .rd_page(rd_page), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready(ready), .prog_stb(prog_stb), .erase_stb(erase_stb),
        .range_first(range_first), .range_count(range_count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_addr(input int pg14);
        return {7'h6B, 14'(pg14), 11'h5A3};
    endfunction

    task automatic cmp_page(input string req, input int pg);
        int bad_act = 0;
        int bad_exp = 0;
        bit ok = 1'b1;
        for (int b = 0; b < PB; b++) begin
            rd_page = 5'(pg);
            rd_addr = 3'(b);
            #0.5;
            if (ok && (int'(rd_data) != mdl[pg][b])) begin
                ok = 1'b0;
                bad_act = int'(rd_data);
                bad_exp = mdl[pg][b];
            end
        end
        chk(req, $sformatf("page %0d content", pg), ok ? 0 : bad_act, ok ? 0 : bad_exp);
    endtask

    task automatic load_buf(input int s, input int seed);
        for (int b = 0; b < PB; b++) begin
            @(negedge clk);
            buf_wr = 1'b1;
            buf_sel = s[0];
            buf_addr = 3'(b);
            buf_data = 8'((seed ^ (b * 29)) & 255);
            bufm[s][b] = (seed ^ (b * 29)) & 255;
        end
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] op, input logic [31:0] a,
                              input int nab, input bit raise);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i <= nab; i++) begin
            rx_valid = 1'b1;
            rx_byte = (i == 0) ? op : a[31 - 8 * (i - 1) -: 8];
            @(negedge clk);
        end
        rx_valid = 1'b0;
        if (raise) cs_n = 1'b1;
    endtask

    task automatic watch_op(output int bc, output int sc, output int f,
                            output int n, output int pk);
        bc = 0; sc = 0; f = -1; n = 0; pk = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (ready) break;
            bc++;
            if (prog_stb || erase_stb) begin
                sc++;
                f = int'(range_first);
                n = int'(range_count);
                pk = prog_stb ? 1 : 2;
            end
        end
    endtask

    task automatic run_cmd(input string req, input logic [7:0] op, input int pg14,
                           input int exp_busy, input int exp_kind,
                           input int exp_first, input int exp_cnt);
        int bc, sc, f, n, pk;
        send_frame(op, mk_addr(pg14), 4, 1'b1);
        watch_op(bc, sc, f, n, pk);
        chk(req, "busy cycles", bc, exp_busy);
        chk("R12", "strobe count", sc, 1);
        chk("R12", "strobe kind", pk, exp_kind);
        chk("R12", "range_first", f, exp_first);
        chk("R12", "range_count", n, exp_cnt);
    endtask

    function automatic void mdl_prog(input int pg, input int s);
        for (int b = 0; b < PB; b++) mdl[pg][b] = mdl[pg][b] & bufm[s][b];
    endfunction

    function automatic void mdl_erase(input int pg, input int cnt);
        for (int p = pg; p < pg + cnt; p++)
            for (int b = 0; b < PB; b++) mdl[p][b] = 255;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready after reset", int'(ready), 1);
        chk("R1", "strobes after reset", int'(prog_stb) + int'(erase_stb), 0);
        cmp_page("R1", 0);
        cmp_page("R1", NP - 1);
    endtask

    task automatic t_programs();
        load_buf(0, 8'h3C);
        load_buf(1, 8'hA5);
        run_cmd("R2", 8'h88, 3, TP, 1, 3, 1);
        mdl_prog(3, 0);
        cmp_page("R2", 3);
        run_cmd("R2", 8'h99, 9, TF, 1, 9, 1);
        mdl_prog(9, 1);
        cmp_page("R2", 9);
        run_cmd("R2", 8'h89, 16, TP, 1, 16, 1);
        mdl_prog(16, 1);
        cmp_page("R2", 16);
        run_cmd("R5", 8'h98, 7, TF, 1, 7, 1);
        mdl_prog(7, 0);
        cmp_page("R5", 7);
    endtask

    task automatic t_and_merge();
        load_buf(0, 8'hF0);
        run_cmd("R6", 8'h88, 3, TP, 1, 3, 1);
        mdl_prog(3, 0);
        cmp_page("R6", 3);
    endtask

    task automatic t_page_erase();
        run_cmd("R7", 8'h81, 3, TE, 2, 3, 1);
        mdl_erase(3, 1);
        cmp_page("R7", 3);
        cmp_page("R7", 7);
        cmp_page("R7", 9);
    endtask

    task automatic t_block_erase();
        run_cmd("R8", 8'h50, 13, TB, 2, 8, 8);
        mdl_erase(8, 8);
        cmp_page("R8", 9);
        cmp_page("R8", 7);
        cmp_page("R8", 16);
    endtask

    task automatic t_addr_field();
        load_buf(0, 8'h17);
        run_cmd("R3", 8'h88, 14'h2000 | 21, TP, 1, 21, 1);
        mdl_prog(21, 0);
        cmp_page("R3", 21);
    endtask

    task automatic t_abort();
        int bc, sc, f, n, pk;
        send_frame(8'h81, mk_addr(21), 3, 1'b1);
        watch_op(bc, sc, f, n, pk);
        chk("R10", "busy after short frame", bc, 0);
        repeat (3) @(negedge clk);
        chk("R10", "ready after short frame", int'(ready), 1);
        cmp_page("R10", 21);
    endtask

    task automatic t_unknown();
        int bc, sc, f, n, pk;
        send_frame(8'h82, mk_addr(21), 4, 1'b1);
        watch_op(bc, sc, f, n, pk);
        chk("R11", "busy after unknown code", bc, 0);
        cmp_page("R11", 21);
    endtask

    task automatic t_cs_hold();
        int bc, sc, f, n, pk;
        int lows = 0;
        send_frame(8'h81, mk_addr(21), 4, 1'b0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!ready) lows++;
        end
        chk("R4", "busy cycles with cs low", lows, 0);
        cs_n = 1'b1;
        watch_op(bc, sc, f, n, pk);
        chk("R4", "busy after release", bc, TE);
        mdl_erase(21, 1);
        cmp_page("R4", 21);
    endtask

    task automatic t_busy_ignore();
        int lows = 0;
        load_buf(1, 0);
        send_frame(8'h50, mk_addr(24), 4, 1'b1);
        send_frame(8'h89, mk_addr(5), 4, 1'b1);
        chk("R9", "still busy after second frame", int'(ready), 0);
        for (int k = 0; k < 100 && !ready; k++) @(negedge clk);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!ready) lows++;
        end
        chk("R9", "busy cycles after first op", lows, 0);
        mdl_erase(24, 8);
        cmp_page("R9", 5);
        cmp_page("R9", 24);
    endtask

    initial begin
        for (int p = 0; p < NP; p++)
            for (int b = 0; b < PB; b++) mdl[p][b] = 255;
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < PB; b++) bufm[s][b] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_programs();
        t_and_merge();
        t_page_erase();
        t_block_erase();
        t_addr_field();
        t_abort();
        t_unknown();
        t_cs_hold();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule